// File: doc/BRIEF.md
# Snooping Line-State Coherence Agent

This block sits beside one private cache and keeps it coherent with the other caches on a shared bus. For each cache set it holds one tag and a line state: invalid, clean or dirty. Every read or write that another processor puts on the bus is looked up against the local tags. A clean copy survives a remote read and is dropped on a remote write. A dirty copy means this cache holds the only valid data, so the agent supplies the line to the requester itself in eight beats and memory stays out of the transfer. The line is then demoted to clean after a remote read, and memory is told to capture the beats. After a remote write the line is invalidated.

The local core reports its own events on a second port. A fill installs a line as clean. A write to a line that is not already dirty first announces a write-intent on the bus, so that every other cache drops its copy, and only then is the line marked dirty. The data array, the memory controller and bus arbitration are outside the block. The bus is assumed to issue no new request while a response or intervention from this agent is in progress. Addresses on every port are line addresses, with the byte offset already removed. The low `SET_W` bits select the set and the remaining bits form the tag.

Top module: `coh_snoop_agent`

## Requirements
- R1: After reset every line reads invalid on the query port, and `rsp_valid`, `ivn_valid`, `mem_capture` and `bi_valid` are low.
- R2: A local fill accepted on a cycle with `loc_ready` high installs the line as clean; the query port then returns 2'b01 (the encoding is invalid 2'b00, clean 2'b01, dirty 2'b10).
- R3: Exactly one cycle after each snoop request, `rsp_valid` is high. `rsp_hit` is high only if the line is held (tag matches and state not invalid), and `rsp_dirty` is high only if the held line is dirty.
- R4: A remote read that hits a clean line leaves it clean and produces no data beats.
- R5: A remote write that hits a clean line makes it invalid and produces no data beats.
- R6: A remote read that hits a dirty line produces eight consecutive beats on `ivn_valid`, numbered 0 to 7 on `ivn_beat` and starting the cycle after the response. `mem_capture` is high on each of these beats, and afterwards the line is clean.
- R7: A remote write that hits a dirty line produces the same eight beats with `mem_capture` low throughout, and afterwards the line is invalid.
- R8: A local write to a line that is not dirty raises `bi_valid` carrying that line address for at least one cycle. The line reads dirty only after `bi_valid` has been seen.
- R9: A local write to a line already dirty is accepted without any write-intent broadcast, and the line stays dirty.
- R10: A snoop has priority over local activity in the same cycle. `loc_ready` is held low, and a pending dirty commit is deferred with `bi_valid` held high. The local work completes on the next cycle without a snoop.
- R11: A snoop whose set matches a held line but whose tag differs reports a miss and leaves that line's state unchanged.
- R12: While a dirty-line response or its data beats are in progress, `loc_ready` stays low. A local request held through that time is accepted only after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Remote request observed on the bus this cycle |
| snp_write | input | 1 | Remote request is a write (1) or a read (0) |
| snp_line | input | LINE_W | Line address of the remote request |
| rsp_valid | output | 1 | Snoop response, one cycle after the request |
| rsp_hit | output | 1 | Line was held locally |
| rsp_dirty | output | 1 | Line was held dirty; data beats follow |
| ivn_valid | output | 1 | Intervention data beat active |
| ivn_beat | output | BEAT_W | Beat number within the line |
| ivn_set | output | SET_W | Set whose data array entry supplies the beat |
| mem_capture | output | 1 | Memory should store this beat |
| loc_valid | input | 1 | Local core state update request |
| loc_write | input | 1 | Local write (1) or fill (0) |
| loc_line | input | LINE_W | Line address of the local update |
| loc_ready | output | 1 | Local request accepted at this clock edge |
| bi_valid | output | 1 | Write-intent broadcast on the bus |
| bi_line | output | LINE_W | Line address of the write-intent |
| qry_line | input | LINE_W | Line address to inspect |
| qry_state | output | 2 | State of the queried line (invalid if not held) |

## Verification
Two functions can fall into the same clock cycle: a remote snoop and local activity. The local activity is either a fresh fill or write request, or the deferred dirty commit that follows a write-intent. The bench provokes both cases. It presents a snoop and a local fill in the same cycle and checks that the fill is refused and then accepted one cycle later. It also sends a snoop during the write-intent cycle and checks that the intent stays asserted, that the line is still clean on the next cycle and that it turns dirty only on the cycle after that. A third case holds a local fill through a dirty-line intervention and counts the beats before acceptance.

// File: rtl/coh_pkg.sv
// Shared types for the coherence agent.
// Assumes: nothing; pure type definitions.
package coh_pkg;

    // Per-line coherence record; encoding is visible on qry_state.
    typedef enum logic [1:0] {
        LS_INV   = 2'b00,
        LS_CLEAN = 2'b01,
        LS_DIRTY = 2'b10
    } line_state_e;

    // Local controller sequencing.
    typedef enum logic {
        LC_IDLE = 1'b0,
        LC_OWN  = 1'b1
    } loc_phase_e;

endpackage

// File: rtl/coh_tag_store.sv
// Tag and state storage, one entry per set (direct mapped).
// NRD combinational lookup ports each return the state of the addressed line,
// reporting invalid when the tag differs. One synchronous write port.
// Assumes: callers never need two writes in one cycle.
module coh_tag_store
    import coh_pkg::*;
#(
    parameter int SET_W = 4,
    parameter int TAG_W = 22,
    parameter int NRD   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NRD-1:0][SET_W-1:0]  rd_set,
    input  logic [NRD-1:0][TAG_W-1:0]  rd_tag,
    output logic [NRD-1:0][1:0]        rd_state,
    input  logic                       wr_en,
    input  logic [SET_W-1:0]           wr_set,
    input  logic [TAG_W-1:0]           wr_tag,
    input  line_state_e                wr_state
);

    localparam int NSETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q   [NSETS];
    line_state_e      state_q [NSETS];

    // Line states: cleared to invalid on reset, written by the update port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) state_q[i] <= LS_INV;
        end else if (wr_en) begin
            state_q[wr_set] <= wr_state;
        end
    end

    // Tags: need no reset because an invalid state masks them.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set] <= wr_tag;
    end

    // Lookup ports: state of the addressed line, invalid on tag mismatch.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (tag_q[rd_set[p]] == rd_tag[p]) rd_state[p] = state_q[rd_set[p]];
            else                               rd_state[p] = LS_INV;
        end
    end

endmodule

// File: rtl/coh_snoop_ctl.sv
// Remote-request handling: classifies each snoop against the local state,
// issues the state change, registers the response one cycle later and
// sequences the intervention beats for dirty hits.
// Assumes: the bus sends no snoop while busy is high.
module coh_snoop_ctl
    import coh_pkg::*;
#(
    parameter int SET_W  = 4,
    parameter int BEATS  = 8,
    parameter int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [SET_W-1:0]  snp_set,
    input  line_state_e       lk_state,
    output logic              upd_en,
    output line_state_e       upd_state,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_dirty,
    output logic              ivn_valid,
    output logic [BEAT_W-1:0] ivn_beat,
    output logic [SET_W-1:0]  ivn_set,
    output logic              mem_capture,
    output logic              busy
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    logic              held, held_dirty;
    logic              arm_q, act_q, rd_q;
    logic [BEAT_W-1:0] beat_q;
    logic [SET_W-1:0]  set_q;

    // Classification of the current snoop and the resulting state change.
    always_comb begin
        held       = snp_valid && (lk_state != LS_INV);
        held_dirty = held && (lk_state == LS_DIRTY);
        upd_en     = held && (snp_write || held_dirty);
        upd_state  = snp_write ? LS_INV : LS_CLEAN;
    end

    // Response flags, valid the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_valid <= snp_valid;
            rsp_hit   <= held;
            rsp_dirty <= held_dirty;
        end
    end

    // Intervention sequencer: arm during the response cycle, then BEATS beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            act_q  <= 1'b0;
            rd_q   <= 1'b0;
            beat_q <= '0;
            set_q  <= '0;
        end else begin
            arm_q <= held_dirty;
            if (held_dirty) begin
                rd_q  <= !snp_write;
                set_q <= snp_set;
            end
            if (arm_q) begin
                act_q  <= 1'b1;
                beat_q <= '0;
            end else if (act_q) begin
                if (beat_q == LAST_BEAT) act_q <= 1'b0;
                else                     beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign ivn_valid   = act_q;
    assign ivn_beat    = beat_q;
    assign ivn_set     = set_q;
    assign mem_capture = act_q && rd_q;
    assign busy        = arm_q || act_q;

endmodule

// File: rtl/coh_local_ctl.sv
// Local core updates: fills install clean lines at once. Writes to a line
// that is not dirty enter an ownership phase that broadcasts write-intent
// and commit the dirty state only on a cycle free of snoop activity.
// Assumes: the core holds loc_valid until loc_ready is seen.
module coh_local_ctl
    import coh_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic              loc_write,
    input  logic [LINE_W-1:0] loc_line,
    input  line_state_e       lk_state,
    input  logic              snp_valid,
    input  logic              busy,
    output logic              loc_ready,
    output logic              upd_en,
    output logic [LINE_W-1:0] upd_line,
    output line_state_e       upd_state,
    output logic              bi_valid,
    output logic [LINE_W-1:0] bi_line
);

    loc_phase_e        phase_q;
    logic [LINE_W-1:0] own_q;
    logic              quiet, commit;

    // Acceptance and commit gating: snoop traffic always goes first.
    always_comb begin
        quiet     = !snp_valid && !busy;
        loc_ready = loc_valid && quiet && (phase_q == LC_IDLE);
        commit    = (phase_q == LC_OWN) && quiet;
    end

    // State-update request towards the tag store.
    always_comb begin
        upd_en    = 1'b0;
        upd_line  = loc_line;
        upd_state = LS_CLEAN;
        if (commit) begin
            upd_en    = 1'b1;
            upd_line  = own_q;
            upd_state = LS_DIRTY;
        end else if (loc_ready && !loc_write) begin
            upd_en    = 1'b1;
        end
    end

    // Ownership phase tracking for writes that need a write-intent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= LC_IDLE;
            own_q   <= '0;
        end else if (phase_q == LC_IDLE) begin
            if (loc_ready && loc_write && lk_state != LS_DIRTY) begin
                phase_q <= LC_OWN;
                own_q   <= loc_line;
            end
        end else if (commit) begin
            phase_q <= LC_IDLE;
        end
    end

    assign bi_valid = (phase_q == LC_OWN);
    assign bi_line  = own_q;

endmodule

// File: rtl/coh_snoop_agent.sv
// Top of the coherence agent: splits line addresses into set and tag,
// shares one tag store between snoop, local and query lookups, and gives
// snoop state changes priority on the single write port.
// Assumes: line addresses on all ports; bus holds off new snoops while a
// dirty response or intervention is in progress.
module coh_snoop_agent
    import coh_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 6,
    parameter int SET_W  = 4,
    parameter int BEATS  = 8,
    localparam int LINE_W = ADDR_W - OFS_W,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [LINE_W-1:0] snp_line,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_dirty,
    output logic              ivn_valid,
    output logic [BEAT_W-1:0] ivn_beat,
    output logic [SET_W-1:0]  ivn_set,
    output logic              mem_capture,
    input  logic              loc_valid,
    input  logic              loc_write,
    input  logic [LINE_W-1:0] loc_line,
    output logic              loc_ready,
    output logic              bi_valid,
    output logic [LINE_W-1:0] bi_line,
    input  logic [LINE_W-1:0] qry_line,
    output logic [1:0]        qry_state
);

    localparam int TAG_W = LINE_W - SET_W;
    localparam int NRD   = 3;
    localparam int P_SNP = 0;
    localparam int P_LOC = 1;
    localparam int P_QRY = 2;

    logic [NRD-1:0][SET_W-1:0] rd_set;
    logic [NRD-1:0][TAG_W-1:0] rd_tag;
    logic [NRD-1:0][1:0]       rd_state;

    logic              s_upd_en, l_upd_en, busy;
    line_state_e       s_upd_state, l_upd_state, wr_state;
    logic [LINE_W-1:0] l_upd_line, wr_line;
    logic              wr_en;

    // Lookup address split for the three read ports.
    always_comb begin
        rd_set[P_SNP] = snp_line[SET_W-1:0];
        rd_tag[P_SNP] = snp_line[LINE_W-1:SET_W];
        rd_set[P_LOC] = loc_line[SET_W-1:0];
        rd_tag[P_LOC] = loc_line[LINE_W-1:SET_W];
        rd_set[P_QRY] = qry_line[SET_W-1:0];
        rd_tag[P_QRY] = qry_line[LINE_W-1:SET_W];
    end

    // Write-port arbitration: snoop changes win over local ones.
    always_comb begin
        wr_en    = s_upd_en || l_upd_en;
        wr_line  = s_upd_en ? snp_line : l_upd_line;
        wr_state = s_upd_en ? s_upd_state : l_upd_state;
    end

    coh_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W), .NRD(NRD)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (rd_set),
        .rd_tag   (rd_tag),
        .rd_state (rd_state),
        .wr_en    (wr_en),
        .wr_set   (wr_line[SET_W-1:0]),
        .wr_tag   (wr_line[LINE_W-1:SET_W]),
        .wr_state (wr_state)
    );

    coh_snoop_ctl #(.SET_W(SET_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_valid   (snp_valid),
        .snp_write   (snp_write),
        .snp_set     (snp_line[SET_W-1:0]),
        .lk_state    (line_state_e'(rd_state[P_SNP])),
        .upd_en      (s_upd_en),
        .upd_state   (s_upd_state),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_dirty   (rsp_dirty),
        .ivn_valid   (ivn_valid),
        .ivn_beat    (ivn_beat),
        .ivn_set     (ivn_set),
        .mem_capture (mem_capture),
        .busy        (busy)
    );

    coh_local_ctl #(.LINE_W(LINE_W)) u_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_valid (loc_valid),
        .loc_write (loc_write),
        .loc_line  (loc_line),
        .lk_state  (line_state_e'(rd_state[P_LOC])),
        .snp_valid (snp_valid),
        .busy      (busy),
        .loc_ready (loc_ready),
        .upd_en    (l_upd_en),
        .upd_line  (l_upd_line),
        .upd_state (l_upd_state),
        .bi_valid  (bi_valid),
        .bi_line   (bi_line)
    );

    assign qry_state = rd_state[P_QRY];

endmodule

// File: rtl/coh_snoop_agent_chk.sv
// Protocol checker for the coherence agent, bound to the top module.
// Assumes: observes top-level ports only.
module coh_snoop_agent_chk #(
    parameter int BEAT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snp_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_dirty,
    input logic              ivn_valid,
    input logic [BEAT_W-1:0] ivn_beat,
    input logic              mem_capture,
    input logic              loc_ready,
    input logic              bi_valid
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    AST_RSP_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(snp_valid)); // R3
    AST_DIRTY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_dirty) |-> rsp_hit); // R3
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_dirty) |=> (ivn_valid && ivn_beat == '0)); // R6
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ivn_valid && ivn_beat != LAST_BEAT) |=> (ivn_valid && ivn_beat == $past(ivn_beat) + 1'b1)); // R6
    AST_CAPTURE_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_capture |-> ivn_valid); // R6
    AST_CLEAN_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_dirty) |=> !ivn_valid); // R4
    AST_SNOOP_BLOCKS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !loc_ready); // R10
    AST_INTENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bi_valid && snp_valid) |=> bi_valid); // R10
    AST_NO_LOCAL_IN_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        ivn_valid |-> !loc_ready); // R12

endmodule

bind coh_snoop_agent coh_snoop_agent_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid   (snp_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_dirty   (rsp_dirty),
    .ivn_valid   (ivn_valid),
    .ivn_beat    (ivn_beat),
    .mem_capture (mem_capture),
    .loc_ready   (loc_ready),
    .bi_valid    (bi_valid)
);

// File: tb/coh_snoop_agent_bench.sv
// Directed bench for the coherence agent: one task per scenario.
module coh_snoop_agent_bench;

    localparam int LW = 26;
    localparam logic [1:0] S_INV = 2'b00, S_CLEAN = 2'b01, S_DIRTY = 2'b10;
    localparam logic [LW-1:0] LN_A = 26'h41;   // set 1, tag 4
    localparam logic [LW-1:0] LN_B = 26'h81;   // set 1, tag 8 (alias of A)
    localparam logic [LW-1:0] LN_C = 26'h42;   // set 2
    localparam logic [LW-1:0] LN_D = 26'h105;  // set 5, never filled
    localparam logic [LW-1:0] LN_E = 26'h43;   // set 3

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snp_valid = 1'b0, snp_write = 1'b0;
    logic [LW-1:0] snp_line = '0;
    logic          rsp_valid, rsp_hit, rsp_dirty, ivn_valid, mem_capture;
    logic [2:0]    ivn_beat;
    logic [3:0]    ivn_set;
    logic          loc_valid = 1'b0, loc_write = 1'b0;
    logic [LW-1:0] loc_line = '0;
    logic          loc_ready, bi_valid;
    logic [LW-1:0] bi_line;
    logic [LW-1:0] qry_line = '0;
    logic [1:0]    qry_state;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    coh_snoop_agent u_coh_snoop_agent (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_line(snp_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
        .ivn_valid(ivn_valid), .ivn_beat(ivn_beat), .ivn_set(ivn_set),
        .mem_capture(mem_capture),
        .loc_valid(loc_valid), .loc_write(loc_write), .loc_line(loc_line),
        .loc_ready(loc_ready), .bi_valid(bi_valid), .bi_line(bi_line),
        .qry_line(qry_line), .qry_state(qry_state)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic read_state(input logic [LW-1:0] ln, output int st);
        qry_line = ln;
        #1;
        st = qry_state;
    endtask

    // Remote request; collects response flags, beats and captures.
    task automatic snoop_op(input logic wr, input logic [LW-1:0] ln,
                            output int rv, output int hit, output int drt,
                            output int beats, output int caps, output int order_bad);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = wr; snp_line = ln;
        @(negedge clk);
        snp_valid = 1'b0; snp_write = 1'b0;
        #1;
        rv = rsp_valid; hit = rsp_hit; drt = rsp_dirty;
        beats = 0; caps = 0; order_bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1;
            if (ivn_valid) begin
                if (int'(ivn_beat) != beats) order_bad++;
                if (ivn_set != ln[3:0]) order_bad++;
                beats++;
                if (mem_capture) caps++;
            end
        end
    endtask

    // Local fill or write; observes write-intent and state ordering.
    task automatic local_op(input logic wr, input logic [LW-1:0] ln,
                            output int acc, output int bi_cnt,
                            output int early_dirty, output int bi_bad);
        acc = 0;
        @(negedge clk);
        loc_valid = 1'b1; loc_write = wr; loc_line = ln;
        for (int i = 0; i < 20 && acc == 0; i++) begin
            #1;
            if (loc_ready) acc = 1;
            @(negedge clk);
        end
        loc_valid = 1'b0; loc_write = 1'b0;
        bi_cnt = 0; early_dirty = 0; bi_bad = 0;
        for (int i = 0; i < 4; i++) begin
            qry_line = ln;
            #1;
            if (bi_valid) begin
                bi_cnt++;
                if (bi_line != ln) bi_bad++;
                if (qry_state == S_DIRTY) early_dirty++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int st;
        @(negedge clk);
        check("R1", "rsp_valid", rsp_valid, 0);
        check("R1", "ivn_valid", ivn_valid, 0);
        check("R1", "mem_capture", mem_capture, 0);
        check("R1", "bi_valid", bi_valid, 0);
        read_state(LN_A, st); check("R1", "state A", st, S_INV);
        read_state(LN_D, st); check("R1", "state D", st, S_INV);
    endtask

    task automatic t_fill_and_alias;
        int acc, bc, ed, bb, st, rv, h, d, nb, nc, ob;
        local_op(1'b0, LN_A, acc, bc, ed, bb);
        check("R2", "fill accepted", acc, 1);
        check("R2", "fill no intent", bc, 0);
        read_state(LN_A, st); check("R2", "state after fill", st, S_CLEAN);
        snoop_op(1'b1, LN_B, rv, h, d, nb, nc, ob);
        check("R11", "alias rsp_valid", rv, 1);
        check("R11", "alias hit", h, 0);
        read_state(LN_A, st); check("R11", "A kept after alias write", st, S_CLEAN);
        snoop_op(1'b0, LN_D, rv, h, d, nb, nc, ob);
        check("R3", "miss hit", h, 0);
        check("R3", "miss dirty", d, 0);
    endtask

    task automatic t_clean_remote;
        int st, rv, h, d, nb, nc, ob;
        snoop_op(1'b0, LN_A, rv, h, d, nb, nc, ob);
        check("R3", "clean read rsp_valid", rv, 1);
        check("R3", "clean read hit", h, 1);
        check("R3", "clean read dirty", d, 0);
        check("R4", "clean read beats", nb, 0);
        read_state(LN_A, st); check("R4", "state after remote read", st, S_CLEAN);
        snoop_op(1'b1, LN_A, rv, h, d, nb, nc, ob);
        check("R5", "clean write hit", h, 1);
        check("R5", "clean write beats", nb, 0);
        read_state(LN_A, st); check("R5", "state after remote write", st, S_INV);
    endtask

    task automatic t_local_write;
        int acc, bc, ed, bb, st;
        local_op(1'b0, LN_A, acc, bc, ed, bb);
        local_op(1'b1, LN_A, acc, bc, ed, bb);
        check("R8", "write accepted", acc, 1);
        check("R8", "intent cycles", bc, 1);
        check("R8", "intent line mismatches", bb, 0);
        check("R8", "dirty during intent", ed, 0);
        read_state(LN_A, st); check("R8", "state after intent", st, S_DIRTY);
        local_op(1'b1, LN_A, acc, bc, ed, bb);
        check("R9", "rewrite accepted", acc, 1);
        check("R9", "rewrite intent cycles", bc, 0);
        read_state(LN_A, st); check("R9", "state after rewrite", st, S_DIRTY);
    endtask

    task automatic t_dirty_remote;
        int acc, bc, ed, bb, st, rv, h, d, nb, nc, ob;
        snoop_op(1'b0, LN_A, rv, h, d, nb, nc, ob);
        check("R6", "dirty read hit", h, 1);
        check("R6", "dirty read dirty", d, 1);
        check("R6", "read beats", nb, 8);
        check("R6", "read captures", nc, 8);
        check("R6", "beat order errors", ob, 0);
        read_state(LN_A, st); check("R6", "state after dirty read", st, S_CLEAN);
        local_op(1'b1, LN_A, acc, bc, ed, bb);
        snoop_op(1'b1, LN_A, rv, h, d, nb, nc, ob);
        check("R7", "dirty write dirty", d, 1);
        check("R7", "write beats", nb, 8);
        check("R7", "write captures", nc, 0);
        check("R7", "beat order errors", ob, 0);
        read_state(LN_A, st); check("R7", "state after dirty write", st, S_INV);
    endtask

    task automatic t_collision;
        int st;
        @(negedge clk);
        snp_valid = 1'b1; snp_write = 1'b0; snp_line = LN_D;
        loc_valid = 1'b1; loc_write = 1'b0; loc_line = LN_E;
        #1; check("R10", "ready with snoop", loc_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        check("R10", "snoop answered", rsp_valid, 1);
        check("R10", "ready after snoop", loc_ready, 1);
        @(negedge clk);
        loc_valid = 1'b0;
        read_state(LN_E, st); check("R10", "fill landed", st, S_CLEAN);
        // Snoop during the write-intent cycle defers the dirty commit.
        @(negedge clk);
        loc_valid = 1'b1; loc_write = 1'b1; loc_line = LN_E;
        #1; check("R10", "write ready", loc_ready, 1);
        @(negedge clk);
        loc_valid = 1'b0; loc_write = 1'b0;
        snp_valid = 1'b1; snp_write = 1'b0; snp_line = LN_E;
        #1; check("R10", "intent raised", bi_valid, 1);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        check("R10", "intent held", bi_valid, 1);
        check("R10", "snoop saw clean", rsp_dirty, 0);
        read_state(LN_E, st); check("R10", "commit deferred", st, S_CLEAN);
        @(negedge clk);
        #1;
        check("R10", "intent dropped", bi_valid, 0);
        read_state(LN_E, st); check("R10", "commit done", st, S_DIRTY);
    endtask

    task automatic t_busy_block;
        int acc, bc, ed, bb, st, nb, viol, acc_at;
        local_op(1'b1, LN_C, acc, bc, ed, bb);
        read_state(LN_C, st); check("R12", "C made dirty", st, S_DIRTY);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = 1'b0; snp_line = LN_C;
        loc_valid = 1'b1; loc_write = 1'b0; loc_line = LN_A;
        nb = 0; viol = 0; acc = 0; acc_at = -1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            snp_valid = 1'b0;
            if (acc == 1) loc_valid = 1'b0;
            #1;
            if (ivn_valid) nb++;
            if (loc_valid && loc_ready) begin
                if (ivn_valid) viol++;
                if (acc == 0) begin acc = 1; acc_at = nb; end
            end
        end
        loc_valid = 1'b0;
        check("R12", "ready during beats", viol, 0);
        check("R12", "beats before accept", acc_at, 8);
        read_state(LN_A, st); check("R12", "held fill landed", st, S_CLEAN);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_and_alias();
        t_clean_remote();
        t_local_write();
        t_dirty_remote();
        t_collision();
        t_busy_block();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule